// File: doc/BRIEF.md
# Packed-BCD Adder-Subtractor ALU

This block is the add-with-carry and subtract-with-borrow unit of an 8-bit accumulator processor core. It is purely combinational. The surrounding core presents the accumulator, the operand byte, the carry flag, the decimal-mode flag and an add/subtract select. In the same cycle the block returns the new accumulator byte and the carry, overflow, negative and zero flags.

In binary mode it is an ordinary two's-complement adder. For subtraction it adds the inverted operand, so a carry of 1 means "no borrow". In decimal mode each byte holds two packed BCD digits, and the block corrects the digits after the binary operation. The flags in decimal mode follow the original NMOS silicon rather than the corrected result. For addition, zero comes from the raw binary sum, while negative and overflow come from a half-corrected sum (low digit fixed, high digit not yet fixed). For subtraction, every flag comes from the binary difference and only the result byte is corrected. Some software relies on these quirks, so the block reproduces them exactly.

Top module: `bcd_alu`

## Requirements
- R1: Binary add (subtractSel=0, decimalMode=0): result equals the low 8 bits of opA + opB + carryIn, and carryOut equals bit 8 of that 9-bit sum.
- R2: In binary mode, negative is bit 7 of result and zero is 1 exactly when result is 0x00.
- R3: In binary add, overflow is 1 exactly when opA and opB have the same bit 7 and the sum's bit 7 differs from that of opA.
- R4: Subtract (subtractSel=1, either mode): the binary difference is opA − opB − 1 + carryIn. carryOut is 1 exactly when that difference is zero or positive. In binary mode, result is its low 8 bits.
- R5: In subtract, overflow is bit 7 of ((opA XOR opB) AND (opA XOR difference)).
- R6: Decimal add low-digit correction: let L = opA[3:0] + opB[3:0] + carryIn. The half-corrected sum is the binary sum, plus 6 when 10 ≤ L < 26, minus 10 when L ≥ 26, and unchanged when L < 10.
- R7: Decimal add: zero is 1 exactly when the low 8 bits of the uncorrected binary sum are 0x00, whatever the corrected result is.
- R8: Decimal add: negative is bit 7 of the half-corrected sum. Overflow is bit 7 of (NOT(opA XOR opB) AND (opA XOR half-corrected sum)).
- R9: Decimal add high-digit correction: if the half-corrected sum is 0xA0 or more, carryOut is 1 and result is that sum plus 0x60, truncated to 8 bits. Otherwise carryOut is 0 and result is its low 8 bits.
- R10: Decimal subtract: carryOut, overflow, negative and zero take exactly the values that binary subtract would give for the same inputs.
- R11: Decimal subtract low-digit correction: let D = opA[3:0] − opB[3:0] − 1 + carryIn. If D < −10, 10 is added to the difference byte. If −10 ≤ D < 0, 6 is subtracted. If D ≥ 0, nothing is added or subtracted.
- R12: Decimal subtract high-digit correction: when the full difference is negative, 0x60 is also subtracted from the result byte. Every correction wraps modulo 256.
- R13: Outputs depend only on the present inputs and settle in the same cycle, with no clock or storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | Accumulator value (first operand) |
| opB | input | 8 | Operand byte |
| carryIn | input | 1 | Incoming carry flag (1 = no borrow on subtract) |
| decimalMode | input | 1 | 1 selects packed-BCD correction |
| subtractSel | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| result | output | 8 | Result byte |
| carryOut | output | 1 | Outgoing carry flag |
| overflow | output | 1 | Signed overflow flag |
| negative | output | 1 | Negative flag |
| zero | output | 1 | Zero flag |

## Verification
Both digit corrections can act on one operation. On addition the low-digit +6 can lift the working sum to 0xA0, which then triggers the +0x60 step, as in 0x99 + 0x01. On subtraction a low-digit borrow and a negative full difference can both apply, as in 0x00 − 0x01. Directed vectors set up these combined cases, and also the rarer −10 low-digit path. Each output is then compared with a reference model written from the requirements. The bench also sweeps every combination of mode, operation, carry and both operands, so every overlap of the two corrections is covered and judged on all five outputs.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int WORD_W  = 8;
  localparam int NIB_W   = 4;
  localparam int SUM_W   = WORD_W + 1;
  localparam int WORK_W  = WORD_W + 2;
  localparam int LOW_W   = NIB_W + 1;

  typedef struct packed {
    logic invertB;  // subtract: add the complemented operand
    logic decAdd;   // decimal-mode addition
    logic decSub;   // decimal-mode subtraction
  } aluStrobes_t;
endpackage

// File: rtl/bcd_alu_ctrl.sv
module bcd_alu_ctrl
  import bcd_alu_pkg::*;
(
  input  logic        subtractSel,
  input  logic        decimalMode,
  output aluStrobes_t strobes
);
  always_comb begin
    strobes.invertB = subtractSel;
    strobes.decAdd  = decimalMode & ~subtractSel;
    strobes.decSub  = decimalMode & subtractSel;
  end
endmodule

// File: rtl/bcd_alu_adjust.sv
module bcd_alu_adjust
  import bcd_alu_pkg::*;
(
  input  logic [SUM_W-1:0]  binSum,
  input  logic [LOW_W-1:0]  lowSum,
  input  aluStrobes_t       strobes,
  output logic [WORK_W-1:0] halfSum,
  output logic [WORD_W-1:0] decResult,
  output logic              decCarry
);
  localparam logic [WORK_W-1:0] HI_LIMIT  = WORK_W'(10'h0A0);
  localparam logic [WORD_W-1:0] HI_FIX    = 8'h60;
  localparam logic [WORD_W-1:0] LO_FIX_DN = 8'hFA;  // -6
  localparam logic [WORD_W-1:0] LO_FIX_UP = 8'h0A;  // +10

  logic [WORK_W-1:0] addLowAdj;
  logic [WORD_W-1:0] addRes;
  logic [WORD_W-1:0] subLowAdj;
  logic [WORD_W-1:0] subHighAdj;
  logic [WORD_W-1:0] subRes;
  logic              lowBorrow;

  // addition: fix low digit first, then high digit
  always_comb begin
    if (lowSum >= LOW_W'(10))
      addLowAdj = (lowSum < LOW_W'(26)) ? WORK_W'(6) : (~WORK_W'(10) + WORK_W'(1));
    else
      addLowAdj = '0;
    halfSum  = {1'b0, binSum} + addLowAdj;
    decCarry = (halfSum >= HI_LIMIT);
    addRes   = decCarry ? (halfSum[WORD_W-1:0] + HI_FIX) : halfSum[WORD_W-1:0];
  end

  // subtraction: low nibble sum without carry out of bit 3 means a borrow
  always_comb begin
    lowBorrow  = ~lowSum[NIB_W];
    if (lowBorrow)
      subLowAdj = (lowSum < LOW_W'(6)) ? LO_FIX_UP : LO_FIX_DN;
    else
      subLowAdj = '0;
    subHighAdj = binSum[WORD_W] ? '0 : HI_FIX;
    subRes     = binSum[WORD_W-1:0] + subLowAdj - subHighAdj;
    decResult  = strobes.decSub ? subRes : addRes;
  end

  always_comb begin
    if (strobes.decSub && lowSum[NIB_W] && binSum[WORD_W])
      p_sub_no_fix_r11: assert (decResult == binSum[WORD_W-1:0]);
    if (strobes.decAdd && (lowSum < LOW_W'(10)))
      p_half_equals_bin_r6: assert (halfSum == {1'b0, binSum});
  end
endmodule

// File: rtl/bcd_alu_datapath.sv
module bcd_alu_datapath
  import bcd_alu_pkg::*;
(
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              carryIn,
  input  aluStrobes_t       strobes,
  output logic [WORD_W-1:0] result,
  output logic              carryOut,
  output logic              overflow,
  output logic              negative,
  output logic              zero
);
  logic [WORD_W-1:0] opBEff;
  logic [SUM_W-1:0]  binSum;
  logic [LOW_W-1:0]  lowSum;
  logic [WORK_W-1:0] halfSum;
  logic [WORD_W-1:0] decResult;
  logic              decCarry;
  logic [WORD_W-1:0] flagSrc;
  logic [WORD_W-1:0] addOvVec;
  logic [WORD_W-1:0] subOvVec;

  // one shared adder serves both add and subtract
  always_comb begin
    opBEff = strobes.invertB ? ~opB : opB;
    binSum = {1'b0, opA} + {1'b0, opBEff} + SUM_W'(carryIn);
    lowSum = {1'b0, opA[NIB_W-1:0]} + {1'b0, opBEff[NIB_W-1:0]} + LOW_W'(carryIn);
  end

  bcd_alu_adjust u_adjust (
    .binSum    (binSum),
    .lowSum    (lowSum),
    .strobes   (strobes),
    .halfSum   (halfSum),
    .decResult (decResult),
    .decCarry  (decCarry)
  );

  always_comb begin
    flagSrc  = strobes.decAdd ? halfSum[WORD_W-1:0] : binSum[WORD_W-1:0];
    addOvVec = ~(opA ^ opB) & (opA ^ flagSrc);
    subOvVec = (opA ^ opB) & (opA ^ binSum[WORD_W-1:0]);
    overflow = strobes.invertB ? subOvVec[WORD_W-1] : addOvVec[WORD_W-1];
    negative = flagSrc[WORD_W-1];
    zero     = (binSum[WORD_W-1:0] == '0);
    result   = (strobes.decAdd | strobes.decSub) ? decResult : binSum[WORD_W-1:0];
    carryOut = strobes.decAdd ? decCarry : binSum[WORD_W];
  end

  always_comb begin
    if (!strobes.invertB && !strobes.decAdd)
      p_bin_add_sum_r1: assert ({carryOut, result} == ({1'b0, opA} + {1'b0, opB} + SUM_W'(carryIn)));
    if (!strobes.decAdd && !strobes.decSub)
      p_bin_zero_r2: assert (zero == (result == '0));
    if (!strobes.invertB && !strobes.decAdd)
      p_add_overflow_r3: assert (overflow == ((opA[WORD_W-1] == opB[WORD_W-1]) && (result[WORD_W-1] != opA[WORD_W-1])));
    if (strobes.invertB)
      p_sub_carry_r4: assert (carryOut == (({1'b0, opA} + SUM_W'(carryIn)) > {1'b0, opB}));
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
(
  input  logic [7:0] opA,
  input  logic [7:0] opB,
  input  logic       carryIn,
  input  logic       decimalMode,
  input  logic       subtractSel,
  output logic [7:0] result,
  output logic       carryOut,
  output logic       overflow,
  output logic       negative,
  output logic       zero
);
  aluStrobes_t strobes;

  bcd_alu_ctrl u_ctrl (
    .subtractSel (subtractSel),
    .decimalMode (decimalMode),
    .strobes     (strobes)
  );

  bcd_alu_datapath u_dp (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow),
    .negative (negative),
    .zero     (zero)
  );
endmodule

// File: tb/tb_bcd_alu.sv
`timescale 1ns/100ps
module tb_bcd_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opA = '0, opB = '0;
  logic       carryIn = 1'b0, decimalMode = 1'b0, subtractSel = 1'b0;
  logic [7:0] result;
  logic       carryOut, overflow, negative, zero;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  bcd_alu dut (
    .opA(opA), .opB(opB), .carryIn(carryIn), .decimalMode(decimalMode),
    .subtractSel(subtractSel), .result(result), .carryOut(carryOut),
    .overflow(overflow), .negative(negative), .zero(zero)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic       sub, dec, cin;
    logic [7:0] a, b, res;
    logic       c, v, n, z;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b0,8'h50,8'h50,8'hA0,1'b0,1'b1,1'b1,1'b0}, // R1 R3 signed overflow
    '{1'b0,1'b0,1'b0,8'hFF,8'h01,8'h00,1'b1,1'b0,1'b0,1'b1}, // R1 R2 wrap to zero
    '{1'b1,1'b0,1'b1,8'h50,8'hB0,8'hA0,1'b0,1'b1,1'b1,1'b0}, // R4 R5 borrow and overflow
    '{1'b1,1'b0,1'b1,8'h05,8'h05,8'h00,1'b1,1'b0,1'b0,1'b1}, // R4 equal operands
    '{1'b0,1'b1,1'b0,8'h09,8'h01,8'h10,1'b0,1'b0,1'b0,1'b0}, // R6 low digit +6
    '{1'b0,1'b1,1'b0,8'h99,8'h01,8'h00,1'b1,1'b0,1'b1,1'b0}, // R9 R8 both corrections
    '{1'b0,1'b1,1'b0,8'h50,8'h50,8'h00,1'b1,1'b1,1'b1,1'b0}, // R8 R9 high only
    '{1'b0,1'b1,1'b0,8'h80,8'h80,8'h60,1'b1,1'b1,1'b0,1'b1}, // R7 zero from binary sum
    '{1'b0,1'b1,1'b1,8'h0F,8'h0F,8'h15,1'b0,1'b0,1'b0,1'b0}, // R6 minus-10 path
    '{1'b1,1'b1,1'b1,8'h10,8'h01,8'h09,1'b1,1'b0,1'b0,1'b0}, // R11 low borrow -6
    '{1'b1,1'b1,1'b1,8'h00,8'h01,8'h99,1'b0,1'b0,1'b1,1'b0}, // R12 R10 both borrows
    '{1'b1,1'b1,1'b0,8'h00,8'h0F,8'h9A,1'b0,1'b0,1'b1,1'b0}, // R11 plus-10 path
    '{1'b1,1'b1,1'b1,8'h42,8'h42,8'h00,1'b1,1'b0,1'b0,1'b1}  // R10 zero difference
  };

  task automatic drive(input logic s, input logic d, input logic ci,
                       input logic [7:0] a, input logic [7:0] b);
    subtractSel = s; decimalMode = d; carryIn = ci; opA = a; opB = b;
  endtask

  task automatic check(input string tag, input logic [7:0] eRes,
                       input logic eC, input logic eV, input logic eN, input logic eZ);
    checks++;
    if (result !== eRes || carryOut !== eC || overflow !== eV ||
        negative !== eN || zero !== eZ) begin
      errors++;
      $display("FAIL %s: a=%h b=%h sub=%b dec=%b cin=%b actual res=%h c%b v%b n%b z%b expected res=%h c%b v%b n%b z%b",
               tag, opA, opB, subtractSel, decimalMode, carryIn,
               result, carryOut, overflow, negative, zero, eRes, eC, eV, eN, eZ);
    end
  endtask

  function automatic void refAlu(input int s, input int d, input int ci,
                                 input int a, input int b,
                                 output int r, output int c, output int v,
                                 output int n, output int z);
    int t, lo, w;
    if (s == 0) begin
      t = a + b + ci;
      z = ((t & 255) == 0) ? 1 : 0;
      if (d == 0) begin
        r = t & 255; c = (t >> 8) & 1; n = (t >> 7) & 1;
        v = (((~(a ^ b)) & (a ^ t) & 128) != 0) ? 1 : 0;
      end else begin
        lo = (a & 15) + (b & 15) + ci;
        w = t;
        if (lo >= 10) w = w + ((lo < 26) ? 6 : -10);
        n = (w >> 7) & 1;
        v = (((~(a ^ b)) & (a ^ w) & 128) != 0) ? 1 : 0;
        if (w >= 160) begin c = 1; r = (w + 96) & 255; end
        else begin c = 0; r = w & 255; end
      end
    end else begin
      t  = a - b - 1 + ci;
      lo = (a & 15) - (b & 15) - 1 + ci;
      c  = (t >= 0) ? 1 : 0;
      z  = ((t & 255) == 0) ? 1 : 0;
      n  = ((t & 255) >> 7) & 1;
      v  = ((((a ^ b) & (a ^ t)) & 128) != 0) ? 1 : 0;
      r  = t & 255;
      if (d != 0) begin
        if (lo < 0) r = r + ((lo < -10) ? 10 : -6);
        if (t < 0) r = r - 96;
        r = r & 255;
      end
    end
  endfunction

  initial begin
    int r, c, v, n, z;
    // reset state: all-zero inputs while reset is held
    #3;
    check("R2 reset", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    #40 rst = 1'b0;

    // directed vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].sub, VECS[i].dec, VECS[i].cin, VECS[i].a, VECS[i].b);
      #1;
      check($sformatf("table %0d (R1..R12 per entry)", i),
            VECS[i].res, VECS[i].c, VECS[i].v, VECS[i].n, VECS[i].z);
    end

    // R13: new inputs take effect without any clock edge in between
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 8'h99, 8'h01);
    #1 check("R13 settle", 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 8'h99, 8'h01);
    #1 check("R13 mode change", 8'h9A, 1'b0, 1'b0, 1'b1, 1'b0);

    // exhaustive sweep against the requirement model
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 2; d++)
        for (int ci = 0; ci < 2; ci++)
          for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++) begin
              drive(s[0], d[0], ci[0], a[7:0], b[7:0]);
              #1;
              refAlu(s, d, ci, a, b, r, c, v, n, z);
              check(s == 0 ? (d == 0 ? "R1 R2 R3 sweep" : "R6 R7 R8 R9 sweep")
                           : (d == 0 ? "R4 R5 sweep" : "R10 R11 R12 sweep"),
                    r[7:0], c[0], v[0], n[0], z[0]);
            end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule